// File: doc/BRIEF.md
# Read-back register with polarity control

A word-wide storage register that sits on a shared bidirectional data bus. On a rising clock edge it takes the word on the bus, provided its active-low enable is asserted. The same bus can then carry the stored word back, so whoever owns the bus can confirm what the register holds without a separate read path.

A second, independent output port always presents the stored word. A polarity select chooses between the true and the bit-inverted copy. That port can be switched to high impedance without disturbing storage, writes or read-back. An active-low asynchronous clear empties the register. Both tri-state drivers export their drive-enable as a plain output, so a consumer can tell a driven bus from a floating one without resolving Z.

Top module: `readback_reg`

## Requirements
- R1: With en_ni low and rd_ni high at a rising edge of clk_i, the word on bus_io is stored and appears on q_o from the next sample onward.
- R2: While en_ni and rd_ni are both low, bus_drv_o is 1 and bus_io carries the raw stored word, whatever the value of pol_i.
- R3: A rising edge with en_ni and rd_ni both low leaves the stored word unchanged.
- R4: While en_ni is high, edges store nothing and bus_drv_o is 0. en_ni may change only while clk_i is high.
- R5: With pol_i = 1 the output port shows the stored word. With pol_i = 0 every bit of the output port is the inverse of the stored bit.
- R6: With oe_ni high, q_drv_o is 0 and q_o floats. Writes and read-back still take place, and a word written while the port was off appears once oe_ni returns low.
- R7: rst_ni low forces the stored word to all zeros at once, without a clock, and holds it there even when a write is requested at an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| en_ni | input | 1 | Access enable, active low |
| rd_ni | input | 1 | Read-back request, active low (takes effect with en_ni low) |
| pol_i | input | 1 | Output polarity: 1 true, 0 inverted |
| oe_ni | input | 1 | Output port enable, active low |
| bus_io | inout | W | Shared data bus: write input and read-back path |
| bus_drv_o | output | 1 | 1 while the block drives bus_io |
| q_o | output | W | Tri-stated output port |
| q_drv_o | output | 1 | 1 while q_o is driven |

## Verification
The hardest case to reach from the ports is a write taken while the output port is off. Nothing about it is visible when it happens: the stimulus writes a new word with oe_ni high, then turns the port back on and compares the word with the model. A second hard case is a clear that collides with a pending write. Here the stimulus pulls rst_ni low with en_ni low and a fresh word on the bus, then keeps it low across an edge, so an ordinary reset-then-write order cannot hide a broken override. Read-back is always run with pol_i = 0, so driving the inverted copy onto the bus cannot go unnoticed.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
package rb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_READ = 2'd2
  } rb_op_e;
endpackage

// File: rtl/rb_decode.sv
`timescale 1ns/1ps
module rb_decode
  import rb_pkg::*;
(
  input  logic   en_ni,
  input  logic   rd_ni,
  output rb_op_e op_o
);
  always_comb begin
    if (en_ni)      op_o = OP_IDLE;
    else if (rd_ni) op_o = OP_LOAD;
    else            op_o = OP_READ;
  end
endmodule

// File: rtl/rb_store.sv
`timescale 1ns/1ps
module rb_store
  import rb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  rb_op_e       op_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else begin
      case (op_i)
        OP_LOAD: q_o <= d_i;
        OP_READ: q_o <= q_o;  // own read-back reloads itself
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/rb_out.sv
`timescale 1ns/1ps
module rb_out #(
  parameter int W = 8
) (
  input  logic [W-1:0] st_i,
  input  logic         pol_i,
  output logic [W-1:0] val_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign val_o[i] = pol_i ? st_i[i] : ~st_i[i];
  end
endmodule

// File: rtl/readback_reg.sv
`timescale 1ns/1ps
module readback_reg
  import rb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         rd_ni,
  input  logic         pol_i,
  input  logic         oe_ni,
  inout  wire  [W-1:0] bus_io,
  output logic         bus_drv_o,
  output logic [W-1:0] q_o,
  output logic         q_drv_o
);
  rb_op_e       op;
  logic [W-1:0] store_q;
  logic [W-1:0] out_val;

  rb_decode u_dec (.en_ni(en_ni), .rd_ni(rd_ni), .op_o(op));

  rb_store #(.W(W)) u_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .d_i(bus_io), .q_o(store_q)
  );

  rb_out #(.W(W)) u_out (.st_i(store_q), .pol_i(pol_i), .val_o(out_val));

  assign bus_drv_o = (op == OP_READ);
  assign bus_io    = bus_drv_o ? store_q : {W{1'bz}};
  assign q_drv_o   = ~oe_ni;
  assign q_o       = q_drv_o ? out_val : {W{1'bz}};
endmodule

// File: rtl/rb_chk.sv
`timescale 1ns/1ps
module rb_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_ni,
  input logic         rd_ni,
  input logic         pol_i,
  input logic         oe_ni,
  input logic [W-1:0] bus_io,
  input logic         bus_drv_o,
  input logic [W-1:0] q_o,
  input logic         q_drv_o,
  input logic [W-1:0] store_q
);
  AST_LOAD_TAKES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && rd_ni) |=> store_q == $past(bus_io)) else $error("load");  // R1
  AST_READBACK_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drv_o |-> bus_io == store_q) else $error("readback");  // R2
  AST_READBACK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !rd_ni) |=> $stable(store_q)) else $error("hold rb");  // R3
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> $stable(store_q)) else $error("idle");  // R4
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> !bus_drv_o) else $error("idle drive");  // R4
  AST_OUT_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_drv_o |-> q_o == (pol_i ? store_q : ~store_q)) else $error("pol");  // R5
  AST_OUT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !q_drv_o) else $error("oe");  // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> store_q == '0) else $error("clear");  // R7

  always @(en_ni) begin
    if (rst_ni) begin
      AST_EN_CLK_HIGH: assert (clk_i === 1'b1) else $error("en edge");  // R4
    end
  end
endmodule

bind readback_reg rb_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_ni(en_ni), .rd_ni(rd_ni),
  .pol_i(pol_i), .oe_ni(oe_ni), .bus_io(bus_io), .bus_drv_o(bus_drv_o),
  .q_o(q_o), .q_drv_o(q_drv_o), .store_q(store_q)
);

// File: tb/sim_readback_reg.sv
`timescale 1ns/1ps
module sim_readback_reg;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, en_n = 1'b1, rd_n = 1'b1, pol = 1'b1, oe_n = 1'b0;
  logic       tb_drv = 1'b0;
  logic [7:0] tb_val = '0;
  wire  [7:0] bus_w;
  wire  [7:0] q_w;
  logic       bus_drv, q_drv;
  logic [7:0] model = '0;
  int         vec = 0, bad = 0;
  bit         done = 0;

  assign bus_w = tb_drv ? tb_val : 8'bz;

  readback_reg #(.W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .rd_ni(rd_n), .pol_i(pol),
    .oe_ni(oe_n), .bus_io(bus_w), .bus_drv_o(bus_drv), .q_o(q_w), .q_drv_o(q_drv)
  );

  task automatic chk(input bit ok, input string r, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string r);
    logic [7:0] e;
    chk(q_drv === ~oe_n, r, {7'd0, q_drv}, {7'd0, ~oe_n});
    if (!oe_n) begin
      e = pol ? model : ~model;
      chk(q_w === e, r, q_w, e);
    end
    chk(bus_drv === (!en_n && !rd_n), r, {7'd0, bus_drv}, {7'd0, !en_n && !rd_n});
    if (!en_n && !rd_n) chk(bus_w === model, r, bus_w, model);
  endtask

  // called at posedge+1 (clk high): apply, check, take edge, check
  task automatic step(input logic e, input logic r, input logic p, input logic o,
                      input logic d, input logic [7:0] v, input string tag);
    en_n = e; rd_n = r; pol = p; oe_n = o; tb_drv = d; tb_val = v;
    #0.5 check_outs(tag);
    @(posedge clk);
    if (rst_n && !en_n && rd_n) model = tb_val;
    #1 check_outs(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_outs("R7 reset state");
    rst_n = 1'b1;
    step(1, 1, 1, 0, 0, 8'h00, "R4 idle after reset");
    step(0, 1, 1, 0, 1, 8'hA5, "R1 write A5");
    step(1, 1, 1, 0, 0, 8'h00, "R1 A5 held");
    step(1, 1, 0, 0, 0, 8'h00, "R5 inverted");
    step(0, 0, 0, 0, 0, 8'h00, "R2 readback raw");
    step(0, 0, 0, 0, 0, 8'h00, "R3 readback holds");
    step(1, 1, 1, 0, 1, 8'h3C, "R4 no write en high");
    step(1, 0, 1, 0, 1, 8'hC3, "R4 no drive en high");
    step(1, 1, 1, 1, 0, 8'h00, "R6 port off");
    step(0, 1, 1, 1, 1, 8'h5A, "R6 write while off");
    step(0, 0, 0, 1, 0, 8'h00, "R6 readback while off");
    step(1, 1, 1, 0, 0, 8'h00, "R6 port back on");
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 37 + 1);
      step(0, 1, i[0], 0, 1, v, "R1 write pattern");
      step(1, 1, ~i[0], 0, 0, 8'h00, "R5 pattern pol");
    end
    // clear colliding with a write
    step(0, 1, 1, 0, 1, 8'h81, "R1 pre-clear write");
    en_n = 0; rd_n = 1; tb_drv = 1; tb_val = 8'h7E;
    #0.3 rst_n = 1'b0;
    model = '0;
    #0.2 check_outs("R7 async clear");
    @(posedge clk);
    #1 check_outs("R7 clear overrides write");
    rst_n = 1'b1;
    step(1, 1, 1, 0, 0, 8'h00, "R7 stays zero");
    step(0, 1, 1, 0, 1, 8'h42, "R1 write after clear");
    step(0, 0, 0, 0, 0, 8'h00, "R2 final readback");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule